// File: doc/BRIEF.md
# SDRAM Command Decoder and Data-Mask Pipeline

This block sits at the front of a two-bank synchronous DRAM device model. On every rising clock edge it samples the clock-enable level, chip select, the three command lines, a bank-select bit, an 11-bit address and a two-bit data mask. It turns them into single-cycle, one-hot command strobes for the rest of the model, and it registers the bank, row, column and mode opcode fields that go with each command.

The previous and current clock-enable levels together decide how an edge is read. If both are high, the edge carries an ordinary command. If the level falls, the edge enters power-down, self-refresh or clock suspend, depending on the command lines. A previous level that is low means the internal clock is stopped. While the device is in power-down or self-refresh, only the matching exit strobe can fire.

The data mask has two paths with different delays. The write byte-mask follows the mask inputs with no delay. The read byte output-enable is the inverted mask, taken two live clock edges later. This read path stops while the clock is suspended.

Top module: `sdram_cmd_front`

## Requirements
- R1: Every strobe is registered. It is high for the one cycle after the edge that decoded it, and at most one strobe is high at a time. With chip select low, the active-low {ras_n,cas_n,we_n} codes decode as: 000 mode set, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 auto-refresh, 111 no-op. Chip select high gives the deselect strobe.
- R2: An edge decodes a normal command only when the clock enable sampled at the previous edge and at this edge are both high. When the previous sample is low, no strobe fires except a low-power exit, and the read output-enable pipeline holds its value.
- R3: In normal state, with the previous enable high and the current enable low: chip select low with code 001 gives self-refresh entry, and deselect or no-op gives power-down entry.
- R4: In power-down or self-refresh, every strobe is suppressed except the exit. The exit strobe fires at the first edge that samples the enable high together with deselect or no-op: power-down exit from power-down, self-refresh exit from self-refresh. Other commands sampled with the enable high are ignored.
- R5: For a read or a write, addr[10] high selects the auto-precharge variant strobe instead of the plain one.
- R6: For precharge (code 010), addr[10] low gives the single-bank strobe and addr[10] high gives the all-bank strobe.
- R7: Each normal-decode edge with chip select low registers these fields: bank = bank_sel, row = addr[10:0], column = addr[9:0], opcode = {bank_sel, addr}. At all other edges the fields hold their values.
- R8: wr_mask equals the dqm input in the same cycle, with no register in the path. Bit 1 is the upper byte.
- R9: rd_oe[i] equals the inverse of dqm[i] as it was sampled two clock-live edges earlier. Bit 1 is the upper byte.
- R10: During reset and at the first edge after it, all strobes are low. rd_oe is 0 and the fields are 0. The first edge after reset is treated as following a low enable, so it decodes nothing.
- R11: In normal state, if the enable falls with any command other than those in R3, no strobe fires and the clock is suspended. No low-power state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row command line, active low |
| cas_n | input | 1 | Column command line, active low |
| we_n | input | 1 | Write command line, active low |
| bank_sel | input | 1 | Bank select, also opcode MSB |
| addr | input | 11 | Row/column/opcode address |
| dqm | input | 2 | Data mask, bit 1 upper byte |
| do_modeset | output | 1 | Mode register set strobe |
| do_activate | output | 1 | Bank activate strobe |
| do_read | output | 1 | Read strobe |
| do_read_ap | output | 1 | Read with auto-precharge strobe |
| do_write | output | 1 | Write strobe |
| do_write_ap | output | 1 | Write with auto-precharge strobe |
| do_burst_stop | output | 1 | Burst stop strobe |
| do_pre_one | output | 1 | Single-bank precharge strobe |
| do_pre_all | output | 1 | All-bank precharge strobe |
| do_refresh | output | 1 | Auto-refresh strobe |
| do_sref_enter | output | 1 | Self-refresh entry strobe |
| do_sref_exit | output | 1 | Self-refresh exit strobe |
| do_pdown_enter | output | 1 | Power-down entry strobe |
| do_pdown_exit | output | 1 | Power-down exit strobe |
| do_deselect | output | 1 | Deselect strobe |
| do_nop | output | 1 | No-op strobe |
| bank_q | output | 1 | Registered bank |
| row_q | output | 11 | Registered row |
| col_q | output | 10 | Registered column |
| opcode_q | output | 12 | Registered mode opcode |
| wr_mask | output | 2 | Write byte-mask, zero latency |
| rd_oe | output | 2 | Read byte output-enable, two-cycle latency |

## Verification
The hardest conditions to reach are the edges where the enable level and the device state disagree. One is a read presented with the enable high while in power-down: it must be ignored, and the exit must still come later. Another is a mask that changes on every cycle of a clock suspend: the read pipeline must resume from exactly where it stopped. The stimulus walks the device through each entry and exit. It deliberately places non-idle commands and changing mask values on the suppressed edges, and a bench model of the enable history predicts every strobe and every output-enable value.

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front #(
  parameter int AW = 11,
  parameter int CW = 10,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          bank_sel,
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] dqm,
  output logic          do_modeset,
  output logic          do_activate,
  output logic          do_read,
  output logic          do_read_ap,
  output logic          do_write,
  output logic          do_write_ap,
  output logic          do_burst_stop,
  output logic          do_pre_one,
  output logic          do_pre_all,
  output logic          do_refresh,
  output logic          do_sref_enter,
  output logic          do_sref_exit,
  output logic          do_pdown_enter,
  output logic          do_pdown_exit,
  output logic          do_deselect,
  output logic          do_nop,
  output logic          bank_q,
  output logic [AW-1:0] row_q,
  output logic [CW-1:0] col_q,
  output logic [AW:0]   opcode_q,
  output logic [MW-1:0] wr_mask,
  output logic [MW-1:0] rd_oe
);
  localparam int NS = 16;
  localparam int APB = AW - 1;
  localparam int S_MRS = 0, S_ACT = 1, S_RD = 2, S_RDA = 3, S_WR = 4, S_WRA = 5,
                 S_BST = 6, S_PR1 = 7, S_PRA = 8, S_REF = 9, S_SRI = 10, S_SRO = 11,
                 S_PDI = 12, S_PDO = 13, S_DSL = 14, S_NOP = 15;
  localparam logic [NS-1:0] EXIT_MASK = (NS'(1) << S_SRO) | (NS'(1) << S_PDO);

  typedef enum logic [1:0] {LP_NONE, LP_PDOWN, LP_SREF} lp_t;

  lp_t             lp_state, lp_next;
  logic            cke_q;
  logic [NS-1:0]   strb_q, strb_d;
  logic [MW-1:0]   mk1, mk2;
  logic [2:0]      code;
  logic            idle_in, live_normal, take_fields;

  assign code        = {ras_n, cas_n, we_n};
  assign idle_in     = cs_n | (code == 3'b111);
  assign live_normal = (lp_state == LP_NONE) & cke_q & cke;
  assign take_fields = live_normal & ~cs_n;

  always_comb begin
    strb_d  = '0;
    lp_next = lp_state;
    if (lp_state == LP_NONE) begin
      if (cke_q && cke) begin
        if (cs_n) strb_d[S_DSL] = 1'b1;
        else begin
          case (code)
            3'b000: strb_d[S_MRS] = 1'b1;
            3'b011: strb_d[S_ACT] = 1'b1;
            3'b101: strb_d[addr[APB] ? S_RDA : S_RD] = 1'b1;
            3'b100: strb_d[addr[APB] ? S_WRA : S_WR] = 1'b1;
            3'b110: strb_d[S_BST] = 1'b1;
            3'b010: strb_d[addr[APB] ? S_PRA : S_PR1] = 1'b1;
            3'b001: strb_d[S_REF] = 1'b1;
            default: strb_d[S_NOP] = 1'b1;
          endcase
        end
      end else if (cke_q && !cke) begin
        if (!cs_n && code == 3'b001) begin
          strb_d[S_SRI] = 1'b1;
          lp_next       = LP_SREF;
        end else if (idle_in) begin
          strb_d[S_PDI] = 1'b1;
          lp_next       = LP_PDOWN;
        end
      end
    end else if (cke && idle_in) begin
      strb_d[(lp_state == LP_SREF) ? S_SRO : S_PDO] = 1'b1;
      lp_next = LP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      lp_state <= LP_NONE;
      strb_q   <= '0;
    end else begin
      cke_q    <= cke;
      lp_state <= lp_next;
      strb_q   <= strb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      opcode_q <= '0;
    end else if (take_fields) begin
      bank_q   <= bank_sel;
      row_q    <= addr;
      col_q    <= addr[CW-1:0];
      opcode_q <= {bank_sel, addr};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk1 <= '1;
      mk2 <= '1;
    end else if (cke_q) begin
      mk1 <= dqm;
      mk2 <= mk1;
    end
  end

  assign wr_mask = dqm;
  assign rd_oe   = ~mk2;

  assign do_modeset     = strb_q[S_MRS];
  assign do_activate    = strb_q[S_ACT];
  assign do_read        = strb_q[S_RD];
  assign do_read_ap     = strb_q[S_RDA];
  assign do_write       = strb_q[S_WR];
  assign do_write_ap    = strb_q[S_WRA];
  assign do_burst_stop  = strb_q[S_BST];
  assign do_pre_one     = strb_q[S_PR1];
  assign do_pre_all     = strb_q[S_PRA];
  assign do_refresh     = strb_q[S_REF];
  assign do_sref_enter  = strb_q[S_SRI];
  assign do_sref_exit   = strb_q[S_SRO];
  assign do_pdown_enter = strb_q[S_PDI];
  assign do_pdown_exit  = strb_q[S_PDO];
  assign do_deselect    = strb_q[S_DSL];
  assign do_nop         = strb_q[S_NOP];

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_modeset, do_activate, do_read, do_read_ap, do_write, do_write_ap,
              do_burst_stop, do_pre_one, do_pre_all, do_refresh, do_sref_enter,
              do_sref_exit, do_pdown_enter, do_pdown_exit, do_deselect, do_nop}));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (strb_q == '0) && (rd_oe == '0));

  p_suspend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> $stable(rd_oe) && ((strb_q & ~EXIT_MASK) == '0));

  p_lowpower_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state != LP_NONE) |=> ((strb_q & ~EXIT_MASK) == '0));

  p_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_read_ap || do_write_ap) |-> $past(addr[APB]));

  p_preall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre_all |-> $past(addr[APB]) && $past(!cs_n));

  p_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_activate |-> (bank_q == $past(bank_sel)) && (row_q == $past(addr)));

  p_rdoe_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(cke_q, 2) && $past(cke_q))
      |-> (rd_oe == ~$past(dqm, 2)));
endmodule

// File: tb/sdram_cmd_front_test.sv
`timescale 1ns/100ps
module sdram_cmd_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bank_sel = 1'b0;
  logic [10:0] addr = '0;
  logic [1:0]  dqm = 2'b00;
  logic do_modeset, do_activate, do_read, do_read_ap, do_write, do_write_ap, do_burst_stop;
  logic do_pre_one, do_pre_all, do_refresh, do_sref_enter, do_sref_exit, do_pdown_enter;
  logic do_pdown_exit, do_deselect, do_nop, bank_q;
  logic [10:0] row_q;
  logic [9:0]  col_q;
  logic [11:0] opcode_q;
  logic [1:0]  wr_mask, rd_oe;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic [15:0] strb;
    logic        bank;
    logic [10:0] row;
    logic [9:0]  col;
    logic [11:0] opc;
    logic [1:0]  oe;
  } exp_t;
  exp_t q[$];

  logic        m_ckeq = 1'b0;
  int          m_lp = 0;
  logic [1:0]  m_s1 = 2'b11, m_s2 = 2'b11;
  logic        m_bank = 1'b0;
  logic [10:0] m_row = '0;
  logic [9:0]  m_col = '0;
  logic [11:0] m_opc = '0;

  sdram_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_sel(bank_sel), .addr(addr), .dqm(dqm),
    .do_modeset(do_modeset), .do_activate(do_activate), .do_read(do_read),
    .do_read_ap(do_read_ap), .do_write(do_write), .do_write_ap(do_write_ap),
    .do_burst_stop(do_burst_stop), .do_pre_one(do_pre_one), .do_pre_all(do_pre_all),
    .do_refresh(do_refresh), .do_sref_enter(do_sref_enter), .do_sref_exit(do_sref_exit),
    .do_pdown_enter(do_pdown_enter), .do_pdown_exit(do_pdown_exit),
    .do_deselect(do_deselect), .do_nop(do_nop), .bank_q(bank_q), .row_q(row_q),
    .col_q(col_q), .opcode_q(opcode_q), .wr_mask(wr_mask), .rd_oe(rd_oe));

  always #2 clk = ~clk;

  function automatic logic [15:0] act_strb();
    return {do_nop, do_deselect, do_pdown_exit, do_pdown_enter, do_sref_exit, do_sref_enter,
            do_refresh, do_pre_all, do_pre_one, do_burst_stop, do_write_ap, do_write,
            do_read_ap, do_read, do_activate, do_modeset};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ck, input logic cs, input logic [2:0] cd,
                      input logic bk, input logic [10:0] a, input logic [1:0] dq,
                      input string req);
    exp_t e;
    logic [15:0] s;
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = cd; bank_sel = bk; addr = a; dqm = dq;
    #0.5;
    chk(wr_mask == dq, "R8", "wr_mask", 32'(wr_mask), 32'(dq));
    s = '0;
    if (m_lp == 0) begin
      if (m_ckeq && ck) begin
        if (cs) s[14] = 1'b1;
        else begin
          case (cd)
            3'b000: s[0] = 1'b1;
            3'b011: s[1] = 1'b1;
            3'b101: s[a[10] ? 3 : 2] = 1'b1;
            3'b100: s[a[10] ? 5 : 4] = 1'b1;
            3'b110: s[6] = 1'b1;
            3'b010: s[a[10] ? 8 : 7] = 1'b1;
            3'b001: s[9] = 1'b1;
            default: s[15] = 1'b1;
          endcase
          m_bank = bk; m_row = a; m_col = a[9:0]; m_opc = {bk, a};
        end
      end else if (m_ckeq && !ck) begin
        if (!cs && cd == 3'b001) begin s[10] = 1'b1; m_lp = 2; end
        else if (cs || cd == 3'b111) begin s[12] = 1'b1; m_lp = 1; end
      end
    end else if (ck && (cs || cd == 3'b111)) begin
      s[(m_lp == 2) ? 11 : 13] = 1'b1;
      m_lp = 0;
    end
    if (m_ckeq) begin m_s2 = m_s1; m_s1 = dq; end
    m_ckeq = ck;
    e.strb = s; e.bank = m_bank; e.row = m_row; e.col = m_col; e.opc = m_opc; e.oe = ~m_s2;
    @(posedge clk);
    #1;
    q.push_back(e);
    #0.5;
    if (req.len() > 0) $display("  step for %s", req);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(act_strb() == e.strb, "R1/R2/R3/R4/R5/R6/R11", "strobes", 32'(act_strb()), 32'(e.strb));
        chk({bank_q, row_q, col_q, opcode_q} == {e.bank, e.row, e.col, e.opc}, "R7", "fields",
            32'({bank_q, row_q, opcode_q}), 32'({e.bank, e.row, e.opc}));
        chk(rd_oe == e.oe, "R9", "rd_oe", 32'(rd_oe), 32'(e.oe));
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    repeat (4) @(posedge clk);
    #1;
    chk(act_strb() == 16'h0 && rd_oe == 2'b00, "R10", "reset outputs",
        32'({act_strb(), rd_oe}), 32'h0);
    rst_n = 1'b1;
    step(1, 0, 3'b101, 0, 11'h010, 2'b00, "R10 first edge decodes nothing");
    step(1, 1, 3'b000, 0, 11'h000, 2'b01, "R1 deselect");
    step(1, 0, 3'b111, 0, 11'h000, 2'b10, "R1 nop");
    step(1, 0, 3'b000, 1, 11'h2A5, 2'b11, "R7 mode set opcode");
    step(1, 0, 3'b011, 0, 11'h7FF, 2'b00, "R7 activate row");
    step(1, 0, 3'b101, 1, 11'h123, 2'b01, "R5 read plain");
    step(1, 0, 3'b101, 1, 11'h523, 2'b10, "R5 read auto-precharge");
    step(1, 0, 3'b100, 0, 11'h0FF, 2'b00, "R5 write plain");
    step(1, 0, 3'b100, 0, 11'h4FF, 2'b11, "R5 write auto-precharge");
    step(1, 0, 3'b110, 0, 11'h000, 2'b00, "R1 burst stop");
    step(1, 0, 3'b010, 1, 11'h000, 2'b01, "R6 single bank precharge");
    step(1, 0, 3'b010, 0, 11'h400, 2'b00, "R6 all bank precharge");
    step(1, 0, 3'b001, 0, 11'h000, 2'b10, "R1 auto-refresh");
    step(0, 1, 3'b000, 0, 11'h000, 2'b11, "R3 power-down entry by deselect");
    step(0, 0, 3'b101, 0, 11'h011, 2'b00, "R4 read suppressed in power-down");
    step(1, 0, 3'b100, 0, 11'h022, 2'b01, "R4 write ignored with cke high in power-down");
    step(1, 0, 3'b111, 0, 11'h000, 2'b10, "R4 power-down exit");
    step(1, 0, 3'b111, 0, 11'h000, 2'b00, "R1 nop after exit");
    step(0, 0, 3'b111, 0, 11'h000, 2'b01, "R3 power-down entry by nop");
    step(1, 1, 3'b000, 0, 11'h000, 2'b11, "R4 power-down exit by deselect");
    step(1, 0, 3'b111, 0, 11'h000, 2'b00, "R1 nop");
    step(0, 0, 3'b001, 0, 11'h000, 2'b10, "R3 self-refresh entry");
    step(0, 0, 3'b011, 0, 11'h0AA, 2'b01, "R4 activate suppressed in self-refresh");
    step(0, 1, 3'b000, 0, 11'h000, 2'b11, "R4 held in self-refresh");
    step(1, 0, 3'b111, 0, 11'h000, 2'b00, "R4 self-refresh exit");
    step(1, 0, 3'b111, 0, 11'h000, 2'b01, "R1 nop");
    step(0, 0, 3'b101, 1, 11'h155, 2'b10, "R11 read with cke falling suspends");
    step(0, 0, 3'b100, 0, 11'h066, 2'b11, "R2 suspended edge");
    step(0, 0, 3'b011, 0, 11'h077, 2'b00, "R2 suspended edge");
    step(1, 0, 3'b011, 0, 11'h088, 2'b01, "R2 resume edge still frozen");
    step(1, 0, 3'b101, 0, 11'h099, 2'b10, "R2 live again");
    lf = 8'h5A;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(1, lf[0], lf[3:1], lf[4], {lf[2:0], lf}, lf[6:5], "R9 mixed traffic");
    end
    step(1, 0, 3'b111, 0, 11'h000, 2'b00, "");
    step(1, 0, 3'b111, 0, 11'h000, 2'b00, "");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule